// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block protects a 10 Mb/s transmit path from a station that keeps transmitting because of a fault. It watches the internal transmit enable and counts timebase ticks for as long as that enable stays high. If the count reaches the jabber limit, the block closes its transmit-output gate and raises a jabber flag. The lockout holds for as long as transmit enable stays asserted. The gate reopens only after transmit enable has stayed low, without a break, for the unjab period.

Both limits are parameters in tick counts. A product build can use a 1 ms tick with limits of 100 and 500. A simulation can use a few ticks. The watchdog acts only when the 10 Mb/s mode input is high. In any other mode the gate is open and the jabber state is held clear.

Top module: `tx_jabber_guard`

## Requirements
- R1: After reset, `tx_gate` is 1 and `jabber` is 0.
- R2: When `tx_en` has been high for JAB_TICKS ticks in a row with `mode_10m` high, the block locks out. From the cycle after the clock edge that samples the last of those ticks, `tx_gate` is 0 and `jabber` is 1.
- R3: If `tx_en` goes low before the jabber limit is reached, the jabber count restarts from zero. A later run of fewer than JAB_TICKS ticks does not lock out.
- R4: Only cycles with `tick` high advance a count. Clock cycles without a tick change no count.
- R5: While the block is locked, it stays locked for as long as `tx_en` is high, however many ticks pass.
- R6: A locked block releases after UNJAB_TICKS ticks in a row with `tx_en` low. From the cycle after the edge that samples the last of those ticks, `tx_gate` is 1 and `jabber` is 0.
- R7: Any cycle with `tx_en` high during the unjab wait resets that wait to zero, and the block stays locked.
- R8: While `mode_10m` is 0, `tx_gate` is 1 and `jabber` is 0 from the next cycle on, and both counts are cleared. A lockout in progress is dropped, and `tx_en` activity of any length causes no lockout.
- R9: `jabber` is always the complement of `tx_gate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Internal transmit enable |
| mode_10m | input | 1 | 1 selects 10 Mb/s operation and enables the watchdog |
| tick | input | 1 | Single-cycle timebase tick |
| tx_gate | output | 1 | 1 lets transmit output through, 0 blocks it |
| jabber | output | 1 | Jabber lockout status |

## Verification
A jabber count that is off by one moves the lockout edge by exactly one tick. The bench sweeps run lengths on both sides of each limit, so such an error shows at the cycle after the first wrong tick. A count that fails to clear when `tx_en` drops, or during the unjab wait, shows up the same way: a later short run locks out, or the gate reopens early. The bench checks the outputs after every single clock edge, so a wrong state is reported one cycle after it appears.

// File: rtl/jab_pkg.sv
package jab_pkg;

   typedef enum logic [0:0] {
      JB_RUN  = 1'b0,
      JB_LOCK = 1'b1
   } jb_state_e;

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/jab_tick_counter.sv
module jab_tick_counter #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic hit
);
   localparam int W = jab_pkg::cnt_width(LIMIT);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("jab_tick_counter: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt_q;

   assign hit = inc && !clr && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || hit) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2/R6: the count never passes its terminal value
   assert_cnt_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R4: no tick, no change
   assert_hold_no_tick_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/jab_ctrl_fsm.sv
module jab_ctrl_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic jab_hit,
   input  logic unjab_hit,
   output logic locked
);
   import jab_pkg::*;

   jb_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!enable) begin
         st_d = JB_RUN;
      end else begin
         case (st_q)
            JB_RUN:  if (jab_hit)   st_d = JB_LOCK;
            JB_LOCK: if (unjab_hit) st_d = JB_RUN;
            default: st_d = JB_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= JB_RUN;
      else        st_q <= st_d;
   end

   assign locked = (st_q == JB_LOCK);

   // R8: disabled watchdog cannot be locked on the next cycle
   assert_mode_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !locked);

endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
   parameter int JAB_TICKS   = 100,
   parameter int UNJAB_TICKS = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic mode_10m,
   input  logic tick,
   output logic tx_gate,
   output logic jabber
);
   if (JAB_TICKS < 1 || UNJAB_TICKS < 1) begin : g_bad_cfg
      $error("tx_jabber_guard: tick limits must be at least 1");
   end

   logic locked;
   logic jab_hit, unjab_hit;
   logic jab_clr, unjab_clr;

   assign jab_clr   = !mode_10m || locked  || !tx_en;
   assign unjab_clr = !mode_10m || !locked || tx_en;

   jab_tick_counter #(.LIMIT(JAB_TICKS)) u_jab_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (jab_clr),
      .inc   (tick && tx_en),
      .hit   (jab_hit)
   );

   jab_tick_counter #(.LIMIT(UNJAB_TICKS)) u_unjab_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (unjab_clr),
      .inc   (tick && !tx_en),
      .hit   (unjab_hit)
   );

   jab_ctrl_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (mode_10m),
      .jab_hit   (jab_hit),
      .unjab_hit (unjab_hit),
      .locked    (locked)
   );

   assign jabber  = locked;
   assign tx_gate = !locked;

   // R2: lockout begins only after a tick sampled with tx_en high in 10 Mb/s mode
   assert_lock_cause_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jabber) |-> $past(tx_en && tick && mode_10m));

   // R5: a locked block with tx_en high stays locked
   assert_hold_lock_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (jabber && tx_en && mode_10m) |=> jabber);

   // R6/R8: release comes from an idle tick or from leaving 10 Mb/s mode
   assert_release_cause_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(jabber) |-> $past((!tx_en && tick) || !mode_10m));

   // R9: outputs complementary
   assert_gate_flag_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      tx_gate != jabber);

endmodule

// File: tb/tb_tx_jabber_guard.sv
module tb_tx_jabber_guard;
   localparam int JT = 5;
   localparam int UT = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0;
   logic mode_10m = 1'b1;
   logic tick = 1'b0;
   logic tx_gate, jabber;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit m_lk = 1'b0;
   int m_jc = 0;
   int m_uc = 0;

   always #4 clk = ~clk;

   tx_jabber_guard #(.JAB_TICKS(JT), .UNJAB_TICKS(UT)) dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mode_10m(mode_10m),
      .tick(tick), .tx_gate(tx_gate), .jabber(jabber)
   );

   task automatic check(input string req);
      checks++;
      if (jabber !== m_lk || tx_gate !== !m_lk) begin
         errors++;
         $display("FAIL %s: jabber=%b tx_gate=%b expected jabber=%b tx_gate=%b at %0t",
                  req, jabber, tx_gate, m_lk, !m_lk, $time);
      end
   endtask

   task automatic step(input bit a, input bit t, input bit m, input string req);
      @(negedge clk);
      tx_en = a; tick = t; mode_10m = m;
      @(posedge clk);
      if (!m) begin
         m_lk = 1'b0; m_jc = 0; m_uc = 0;
      end else if (!m_lk) begin
         m_uc = 0;
         if (!a) m_jc = 0;
         else if (t) begin
            if (m_jc == JT - 1) begin m_lk = 1'b1; m_jc = 0; end
            else m_jc++;
         end
      end else begin
         m_jc = 0;
         if (a) m_uc = 0;
         else if (t) begin
            if (m_uc == UT - 1) begin m_lk = 1'b0; m_uc = 0; end
            else m_uc++;
         end
      end
      #2;
      check(req);
   endtask

   task automatic settle();
      for (int i = 0; i < UT + 2; i++) step(1'b0, 1'b1, 1'b1, "R6");
   endtask

   task automatic lock_up();
      for (int i = 0; i < JT; i++) step(1'b1, 1'b1, 1'b1, "R2");
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b1, "R1");

      // R3: run lengths below the limit, each followed by a drop
      for (int n = 1; n < JT; n++) begin
         for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b1, "R3");
         step(1'b0, 1'b0, 1'b1, "R3");
      end
      // R3: drop then JT-1 more ticks still no lockout
      for (int i = 0; i < JT - 1; i++) step(1'b1, 1'b1, 1'b1, "R3");
      step(1'b0, 1'b1, 1'b1, "R3");

      // R2: exact limit locks out
      lock_up();
      settle();

      // R4: long stretches without ticks do not count
      for (int i = 0; i < JT - 1; i++) begin
         step(1'b1, 1'b1, 1'b1, "R4");
         for (int k = 0; k < 3 * JT; k++) step(1'b1, 1'b0, 1'b1, "R4");
      end
      step(1'b1, 1'b1, 1'b1, "R4");

      // R5: hold tx_en high for many ticks while locked
      for (int i = 0; i < 6 * UT; i++) step(1'b1, 1'b1, 1'b1, "R5");

      // R7: broken unjab waits of every length keep the lock
      for (int k = 1; k < UT; k++) begin
         for (int i = 0; i < k; i++) step(1'b0, 1'b1, 1'b1, "R7");
         step(1'b1, 1'b0, 1'b1, "R7");
      end
      // R6: unbroken wait with sparse ticks releases
      for (int i = 0; i < UT; i++) begin
         step(1'b0, 1'b0, 1'b1, "R6");
         step(1'b0, 1'b1, 1'b1, "R6");
      end

      // R8: leaving 10 Mb/s mode drops a lockout and blocks new ones
      lock_up();
      step(1'b1, 1'b1, 1'b0, "R8");
      for (int i = 0; i < 4 * JT; i++) step(1'b1, 1'b1, 1'b0, "R8");
      // R8: counts cleared, so JT-1 ticks after return do not lock
      for (int i = 0; i < JT - 1; i++) step(1'b1, 1'b1, 1'b1, "R8");
      step(1'b1, 1'b1, 1'b1, "R2");
      for (int i = 0; i < UT - 1; i++) step(1'b0, 1'b1, 1'b1, "R8");
      step(1'b0, 1'b0, 1'b0, "R8");
      step(1'b0, 1'b0, 1'b1, "R9");
      settle();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule